// File: doc/BRIEF.md
# Core Memory Cycle Controller

This block runs the access cycles of a magnetic-core style memory, where every read wipes the location it reads. A processor hands it a 16-bit address, a direction flag and an 18-bit word. The controller splits the address into an X drive line, a Y drive line and a one-hot bank select. It then steps through a fixed micro-sequence of one clock per phase: clear (destructive read), sense, output strobe, restore-or-write, and done.

On a read, the sensed word is captured in an 18-bit data register. It is presented on the read-data output and written back to the same location, so the stack ends up unchanged. On a write, the data register takes the incoming word, the location is cleared, and the word is then written with the inhibit (zone) enable active.

A power-fail input never cuts a cycle short. A cycle that has started runs through its restore or write and its done phase. The controller then parks in a halted state that only reset leaves.

Top module: `core_cycle_ctrl`

## Requirements
- R1: While busy, `x_line` equals request address bits 6..0 and `y_line` equals bits 12..7 of the accepted request.
- R2: While busy, `bank_sel` has exactly bit n set, where n is address bits 15..13; while not busy, `bank_sel` is all zero.
- R3: After the clock edge that accepts a request, the phases follow in consecutive cycles: clear (`stk_clr` high for one cycle), sense, strobe, store (`stk_wr` high for one cycle, three cycles after `stk_clr`), done.
- R4: On a read, `stk_wdata` is zero during the sense phase, carries the sensed word from the strobe phase on, and `rd_data` holds that word from the store phase until the next read's strobe; writes leave `rd_data` unchanged.
- R5: A read writes the sensed word back during store, so the location holds its old value once the cycle ends.
- R6: On a write, `stk_wdata` carries the request word from the sense phase on, and the location holds that word once the cycle ends.
- R7: `zone_en` is high only in the store phase of a write cycle, never during a read's restore.
- R8: `busy` is high from the cycle after acceptance through the done phase; `done` is a single-cycle pulse in the last busy cycle.
- R9: A request presented while busy is ignored: the running cycle's address outputs do not change and no further cycle follows.
- R10: Power-fail raised during a cycle lets it complete, including its store, after which `halted` stays high and no request is accepted until reset.
- R11: Power-fail seen while idle moves the block to halted on the next edge, and a request in that same cycle is not accepted.
- R12: After synchronous active-low reset, `busy`, `done`, `halted`, `stk_clr`, `stk_wr`, `zone_en`, `bank_sel` and `rd_data` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present; taken only when idle |
| req_write | input | 1 | 1 = write cycle, 0 = read cycle |
| req_addr | input | 16 | Request address |
| req_wdata | input | 18 | Word to write |
| pwr_fail | input | 1 | Power failing; finish and halt |
| busy | output | 1 | Cycle in progress |
| done | output | 1 | One-cycle completion pulse |
| halted | output | 1 | Stopped after power fail |
| rd_data | output | 18 | Last word read |
| x_line | output | 7 | X drive line select |
| y_line | output | 6 | Y drive line select |
| bank_sel | output | 8 | One-hot bank select |
| stk_clr | output | 1 | Destructive read / clear strobe to stack |
| stk_sense | input | 18 | Sensed word from the stack |
| stk_wr | output | 1 | Restore or write strobe to stack |
| stk_wdata | output | 18 | Data register driven to the stack |
| zone_en | output | 1 | Inhibit enable during write |

## Verification
The hardest situation to reach is a second event arriving while a cycle is part way through: a new request, or power-fail, landing after the destructive clear but before the restore. If either one disturbed the sequence, a word would be lost. The bench injects both in the sense phase, a fixed two cycles after acceptance. It then confirms through the stack model that the store still happened and that the stray request touched nothing. A read of a location after an earlier read of the same location shows that each restore left the contents intact.

// File: rtl/core_pkg.sv
// Shared types for the core memory cycle controller.
// Assumes one clock per phase; the encoding of the phases is internal only.
package core_pkg;

    typedef enum logic [2:0] {
        PH_IDLE   = 3'd0,
        PH_CLEAR  = 3'd1,
        PH_SENSE  = 3'd2,
        PH_STROBE = 3'd3,
        PH_STORE  = 3'd4,
        PH_DONE   = 3'd5,
        PH_HALT   = 3'd6
    } phase_t;

endpackage

// File: rtl/core_addr_latch.sv
// Captures the request address on acceptance and splits it into the X line,
// the Y line and a one-hot bank select. Assumes fields are packed X lowest,
// then Y, then bank. Bank select is gated off whenever no cycle runs.
module core_addr_latch #(
    parameter int X_W = 7,
    parameter int Y_W = 6,
    parameter int B_W = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load,
    input  logic                      active,
    input  logic [X_W+Y_W+B_W-1:0]    addr_in,
    output logic [X_W-1:0]            x_line,
    output logic [Y_W-1:0]            y_line,
    output logic [(1<<B_W)-1:0]       bank_sel
);

    localparam int NB = 1 << B_W;
    localparam int Y_LO = X_W;
    localparam int B_LO = X_W + Y_W;

    logic [X_W-1:0] x_q;
    logic [Y_W-1:0] y_q;
    logic [B_W-1:0] b_q;

    // Hold the address fields of the accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q <= '0;
            y_q <= '0;
            b_q <= '0;
        end else if (load) begin
            x_q <= addr_in[X_W-1:0];
            y_q <= addr_in[Y_LO +: Y_W];
            b_q <= addr_in[B_LO +: B_W];
        end
    end

    assign x_line = x_q;
    assign y_line = y_q;

    // One decoder output per bank.
    for (genvar i = 0; i < NB; i++) begin : g_bank
        assign bank_sel[i] = active && (b_q == B_W'(i));
    end

endmodule

// File: rtl/core_phase_seq.sv
// Phase sequencer: steps IDLE -> CLEAR -> SENSE -> STROBE -> STORE -> DONE,
// one clock each, and parks in HALT after power fail. Assumes power fail
// never aborts a started cycle; it is remembered and acted on at DONE.
module core_phase_seq
    import core_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   req_valid,
    input  logic   req_write,
    input  logic   pwr_fail,
    output phase_t phase,
    output logic   accept,
    output logic   cyc_write,
    output logic   busy,
    output logic   done,
    output logic   halted,
    output logic   stk_clr,
    output logic   stk_wr,
    output logic   zone_en
);

    phase_t phase_q, phase_d;
    logic   pf_pend_q;

    assign accept = (phase_q == PH_IDLE) && req_valid && !pwr_fail;

    // Next phase from the current one and the inputs.
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:   if (pwr_fail) phase_d = PH_HALT;
                       else if (req_valid) phase_d = PH_CLEAR;
            PH_CLEAR:  phase_d = PH_SENSE;
            PH_SENSE:  phase_d = PH_STROBE;
            PH_STROBE: phase_d = PH_STORE;
            PH_STORE:  phase_d = PH_DONE;
            PH_DONE:   phase_d = (pf_pend_q || pwr_fail) ? PH_HALT : PH_IDLE;
            PH_HALT:   phase_d = PH_HALT;
            default:   phase_d = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // Direction of the running cycle, captured on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)      cyc_write <= 1'b0;
        else if (accept) cyc_write <= req_write;
    end

    // Remember a power fail seen while a cycle runs.
    always_ff @(posedge clk) begin
        if (!rst_n)                                       pf_pend_q <= 1'b0;
        else if (accept)                                  pf_pend_q <= 1'b0;
        else if (phase_q != PH_IDLE && phase_q != PH_HALT) pf_pend_q <= pf_pend_q | pwr_fail;
    end

    assign phase   = phase_q;
    assign busy    = (phase_q != PH_IDLE) && (phase_q != PH_HALT);
    assign done    = (phase_q == PH_DONE);
    assign halted  = (phase_q == PH_HALT);
    assign stk_clr = (phase_q == PH_CLEAR);
    assign stk_wr  = (phase_q == PH_STORE);
    assign zone_en = (phase_q == PH_STORE) && cyc_write;

endmodule

// File: rtl/core_data_path.sv
// Data register and read-data output. Assumes the stack presents the sensed
// word during the SENSE phase. On reads the register is zeroed in CLEAR and
// loaded in SENSE; on writes it takes the request word at acceptance.
module core_data_path
    import core_pkg::*;
#(
    parameter int D_W = 18
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           accept,
    input  logic           req_write,
    input  logic [D_W-1:0] req_wdata,
    input  phase_t         phase,
    input  logic           cyc_write,
    input  logic [D_W-1:0] stk_sense,
    output logic [D_W-1:0] data_q,
    output logic [D_W-1:0] rd_data
);

    // Data register: write word, clear pulse, then sense load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (accept && req_write) begin
            data_q <= req_wdata;
        end else if (!cyc_write && phase == PH_CLEAR) begin
            data_q <= '0;
        end else if (!cyc_write && phase == PH_SENSE) begin
            data_q <= stk_sense;
        end
    end

    // Output register, strobed once per read cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                                   rd_data <= '0;
        else if (!cyc_write && phase == PH_STROBE)    rd_data <= data_q;
    end

endmodule

// File: rtl/core_cycle_ctrl.sv
// Top of the core memory cycle controller. Ties the address latch, the phase
// sequencer and the data path together. Assumes the stack clears a location
// on stk_clr and stores stk_wdata on stk_wr, each at the clock edge.
module core_cycle_ctrl
    import core_pkg::*;
#(
    parameter int X_W = 7,
    parameter int Y_W = 6,
    parameter int B_W = 3,
    parameter int D_W = 18
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    req_valid,
    input  logic                    req_write,
    input  logic [X_W+Y_W+B_W-1:0]  req_addr,
    input  logic [D_W-1:0]          req_wdata,
    input  logic                    pwr_fail,
    output logic                    busy,
    output logic                    done,
    output logic                    halted,
    output logic [D_W-1:0]          rd_data,
    output logic [X_W-1:0]          x_line,
    output logic [Y_W-1:0]          y_line,
    output logic [(1<<B_W)-1:0]     bank_sel,
    output logic                    stk_clr,
    input  logic [D_W-1:0]          stk_sense,
    output logic                    stk_wr,
    output logic [D_W-1:0]          stk_wdata,
    output logic                    zone_en
);

    phase_t phase;
    logic   accept;
    logic   cyc_write;

    core_phase_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .pwr_fail  (pwr_fail),
        .phase     (phase),
        .accept    (accept),
        .cyc_write (cyc_write),
        .busy      (busy),
        .done      (done),
        .halted    (halted),
        .stk_clr   (stk_clr),
        .stk_wr    (stk_wr),
        .zone_en   (zone_en)
    );

    core_addr_latch #(.X_W(X_W), .Y_W(Y_W), .B_W(B_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .active   (busy),
        .addr_in  (req_addr),
        .x_line   (x_line),
        .y_line   (y_line),
        .bank_sel (bank_sel)
    );

    core_data_path #(.D_W(D_W)) u_data (
        .clk       (clk),
        .rst_n     (rst_n),
        .accept    (accept),
        .req_write (req_write),
        .req_wdata (req_wdata),
        .phase     (phase),
        .cyc_write (cyc_write),
        .stk_sense (stk_sense),
        .data_q    (stk_wdata),
        .rd_data   (rd_data)
    );

endmodule

// File: rtl/core_cycle_chk.sv
// Property checker for core_cycle_ctrl, attached by bind. Observes ports only.
module core_cycle_chk #(
    parameter int NB = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          busy,
    input logic          done,
    input logic          halted,
    input logic          stk_clr,
    input logic          stk_wr,
    input logic          zone_en,
    input logic [NB-1:0] bank_sel
);

    a_r3_clear_single: assert property (@(posedge clk) disable iff (!rst_n)
        stk_clr |=> !stk_clr);

    a_r3_store_follows_clear: assert property (@(posedge clk) disable iff (!rst_n)
        stk_clr |-> ##3 stk_wr);

    a_r7_zone_in_store: assert property (@(posedge clk) disable iff (!rst_n)
        zone_en |-> stk_wr);

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_store_then_done: assert property (@(posedge clk) disable iff (!rst_n)
        stk_wr |=> done);

    a_r8_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    a_r2_bank_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> ($countones(bank_sel) == 1));

    a_r2_bank_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bank_sel == '0));

    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !busy));

endmodule

bind core_cycle_ctrl core_cycle_chk #(.NB(1 << B_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .done     (done),
    .halted   (halted),
    .stk_clr  (stk_clr),
    .stk_wr   (stk_wr),
    .zone_en  (zone_en),
    .bank_sel (bank_sel)
);

// File: tb/sim_core_cycle_ctrl.sv
module sim_core_cycle_ctrl;

    localparam time PERIOD = 10ns;
    localparam int  NV = 10;

    // Vector table: direction, address, write word, expected read word.
    localparam logic        V_WR [NV] = '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0,
                                          1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    localparam logic [15:0] V_A  [NV] = '{16'h0000, 16'hFFFF, 16'h2081, 16'h2081, 16'h0000,
                                          16'hFFFF, 16'h2081, 16'h4C3A, 16'h0000, 16'h0000};
    localparam logic [17:0] V_D  [NV] = '{18'h2A5A5, 18'h3FFFF, 18'h15555, 18'h0, 18'h0,
                                          18'h0, 18'h0, 18'h0, 18'h00001, 18'h0};
    localparam logic [17:0] V_E  [NV] = '{18'h0, 18'h0, 18'h0, 18'h15555, 18'h2A5A5,
                                          18'h3FFFF, 18'h15555, 18'h0, 18'h0, 18'h00001};

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [17:0] req_wdata = '0;
    logic        pwr_fail = 1'b0;
    logic        busy, done, halted, stk_clr, stk_wr, zone_en;
    logic [17:0] rd_data, stk_wdata;
    logic [17:0] sense_q = '0;
    logic [6:0]  x_line;
    logic [5:0]  y_line;
    logic [7:0]  bank_sel;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [17:0] stk_mem [logic [15:0]];

    always #(PERIOD/2) clk = ~clk;

    core_cycle_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .pwr_fail(pwr_fail),
        .busy(busy), .done(done), .halted(halted), .rd_data(rd_data),
        .x_line(x_line), .y_line(y_line), .bank_sel(bank_sel), .stk_clr(stk_clr),
        .stk_sense(sense_q), .stk_wr(stk_wr), .stk_wdata(stk_wdata), .zone_en(zone_en)
    );

    function automatic logic [17:0] peek(logic [15:0] a);
        return stk_mem.exists(a) ? stk_mem[a] : 18'h0;
    endfunction

    function automatic logic [2:0] bank_idx(logic [7:0] s);
        for (int i = 0; i < 8; i++) if (s[i]) return 3'(i);
        return 3'd0;
    endfunction

    // Destructive-read stack model.
    always @(posedge clk) begin
        logic [15:0] a;
        a = {bank_idx(bank_sel), y_line, x_line};
        if (stk_clr) begin
            sense_q <= peek(a);
            stk_mem[a] = 18'h0;
        end
        if (stk_wr) stk_mem[a] = stk_wdata;
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // mode: 0 plain, 1 stray request in sense phase, 2 power fail in sense phase
    task automatic run_op(input logic wr, input logic [15:0] a, input logic [17:0] d,
                          input logic [17:0] e, input int mode);
        logic [17:0] fin;
        fin = wr ? d : e;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        @(negedge clk);                       // clear phase
        req_valid = 1'b0;
        chk("R3 clear strobe", 32'(stk_clr), 32'd1);
        chk("R8 busy", 32'(busy), 32'd1);
        chk("R1 x line", 32'(x_line), 32'(a[6:0]));
        chk("R1 y line", 32'(y_line), 32'(a[12:7]));
        chk("R2 bank", 32'(bank_sel), 32'(8'd1 << a[15:13]));
        @(negedge clk);                       // sense phase
        chk("R3 sense no strobe", 32'({stk_clr, stk_wr}), 32'd0);
        if (wr) chk("R6 data reg word", 32'(stk_wdata), 32'(d));
        else    chk("R4 data reg cleared", 32'(stk_wdata), 32'd0);
        if (mode == 1) begin
            req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h0000; req_wdata = 18'h0;
        end
        if (mode == 2) pwr_fail = 1'b1;
        @(negedge clk);                       // strobe phase
        req_valid = 1'b0;
        if (mode == 1) chk("R9 address held", 32'({bank_sel, y_line, x_line}),
                           32'({8'd1 << a[15:13], a[12:0]}));
        if (!wr) chk("R4 sensed word", 32'(stk_wdata), 32'(e));
        @(negedge clk);                       // store phase
        chk("R3 store strobe", 32'(stk_wr), 32'd1);
        chk("R7 zone", 32'(zone_en), 32'(wr));
        chk("R5 store data", 32'(stk_wdata), 32'(fin));
        if (!wr) chk("R4 read output", 32'(rd_data), 32'(e));
        @(negedge clk);                       // done phase
        chk("R8 done pulse", 32'({done, busy}), 32'd3);
        @(negedge clk);
        chk("R8 done ends", 32'({done, busy}), 32'd0);
        chk(wr ? "R6 stack word" : "R5 stack restored", 32'(peek(a)), 32'(fin));
    endtask

    initial begin
        #(PERIOD * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset flags", 32'({busy, done, halted, stk_clr, stk_wr, zone_en}), 32'd0);
        chk("R12 reset bank", 32'(bank_sel), 32'd0);
        chk("R12 reset rd_data", 32'(rd_data), 32'd0);

        for (int i = 0; i < NV; i++) run_op(V_WR[i], V_A[i], V_D[i], V_E[i], 0);

        // R4: a write leaves rd_data from the last read.
        run_op(1'b1, 16'h1234, 18'h00003, 18'h0, 0);
        chk("R4 rd_data kept", 32'(rd_data), 32'h1);

        // R9: stray request during a read; location 0 must stay 1.
        run_op(1'b0, 16'h1234, 18'h0, 18'h00003, 1);
        chk("R9 no second cycle", 32'({busy, stk_clr}), 32'd0);
        chk("R9 stray untouched", 32'(peek(16'h0000)), 32'h1);

        // R10: power fail mid-cycle; restore completes, then halted.
        run_op(1'b0, 16'h2081, 18'h0, 18'h15555, 2);
        chk("R10 halted", 32'(halted), 32'd1);
        req_valid = 1'b1; req_write = 1'b1; req_addr = 16'h2081; req_wdata = 18'h0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R10 no accept", 32'({busy, stk_clr, halted}), 32'd1);
        @(negedge clk);
        chk("R10 still halted", 32'({busy, halted}), 32'd1);
        chk("R10 stack intact", 32'(peek(16'h2081)), 32'h15555);

        // R12 then R11: power fail while idle with a request in the same cycle.
        pwr_fail = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 halt cleared", 32'({busy, halted}), 32'd0);
        pwr_fail = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h0000;
        @(negedge clk);
        req_valid = 1'b0; pwr_fail = 1'b0;
        chk("R11 halted not busy", 32'({halted, busy, stk_clr}), 32'd4);
        @(negedge clk);
        chk("R11 halt sticky", 32'({halted, busy}), 32'd2);
        chk("R11 stack untouched", 32'(peek(16'h0000)), 32'h1);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule